// File: doc/BRIEF.md
# Flash Status Poller

This block takes over the busy-wait that follows a program or erase command on a serial flash. After a start trigger, it sends a status-read request to the phase sequencer that drives the flash pins. It takes the status word that comes back and compares it with a programmed expected value. Only the bits chosen by a programmed mask take part in the compare.

If the compare fails, the block releases chip select for a fixed gap and asks for another read. If the compare succeeds, it sets an end flag and stops issuing requests. The end flag can drive an interrupt. Software clears the flag by pulsing a clear input and sends a stop trigger to return the block to idle. A stop trigger that arrives mid-poll cancels further reads without reporting completion.

The command may be 8 or 16 bits wide. A status-width select picks how many status bytes take part in the compare. The opcode, the command width, the status width, the expected value and the mask are all captured when the start trigger is accepted.

Top module: `flash_stat_poller`

## Requirements
- R1: After reset, `seq_req_o`, `seq_cs_o`, `busy_o`, `end_o` and `irq_o` are all 0.
- R2: A start pulse is accepted only in idle, only when `poll_en_i` and `cmd_en_i` are both 1, and only when `stop_i` is 0; otherwise `busy_o` stays 0.
- R3: `seq_req_o` is high for exactly one cycle, in the cycle after an accepted start or after a gap ends. `seq_cs_o` is high from that cycle until the cycle in which `seq_done_i` is sampled.
- R4: A returned status matches when, for every enabled bit, `(status & mask) == (expected & mask)`. `stat_sel_i` = 0 enables bits [7:0] only; `stat_sel_i` = 1 enables bits [15:0].
- R5: On a mismatch, `seq_cs_o` stays low for exactly `CS_GAP` cycles (default 2), after which the next `seq_req_o` follows.
- R6: On a match, `end_o` rises in the cycle after `seq_done_i` is sampled, and no further request is issued.
- R7: `irq_o` is high exactly when `end_o` is 1 and `irq_en_i` is 1.
- R8: `end_o` stays set until a cycle in which `end_clr_i` is 1. If a match and `end_clr_i` fall in the same cycle, the set wins.
- R9: `stop_i` returns the block to idle. If a read is outstanding, the block waits for its `seq_done_i`, ignores that status, leaves `end_o` unchanged and issues no further request.
- R10: A start pulse while the block is polling or finished has no effect.
- R11: The opcode, command width, status width, expected value and mask are captured when the start is accepted; later changes to them have no effect. For an 8-bit command, bits [15:8] of `seq_opcode_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start trigger pulse |
| stop_i | input | 1 | Stop trigger pulse |
| poll_en_i | input | 1 | Polling enable |
| cmd_en_i | input | 1 | Command phase enable |
| cmd_16b_i | input | 1 | 1: 16-bit command, 0: 8-bit command |
| opcode_i | input | 16 | Status-read opcode |
| stat_sel_i | input | SEL_W (1) | Status width select: 0 for one byte, 1 for two bytes |
| expect_i | input | STAT_W (16) | Expected status value |
| mask_i | input | STAT_W (16) | Compare mask |
| end_clr_i | input | 1 | Clear pulse for the end flag |
| irq_en_i | input | 1 | Interrupt enable |
| seq_req_o | output | 1 | Status-read request to the sequencer |
| seq_cs_o | output | 1 | Chip-select request |
| seq_opcode_o | output | 16 | Opcode presented to the sequencer |
| seq_cmd_16b_o | output | 1 | Command width presented to the sequencer |
| seq_stat_sel_o | output | SEL_W (1) | Status width presented to the sequencer |
| seq_done_i | input | 1 | Pulse from the sequencer: status read complete |
| seq_stat_i | input | STAT_W (16) | Status word returned by the sequencer |
| busy_o | output | 1 | Polling in progress |
| end_o | output | 1 | End flag |
| irq_o | output | 1 | End interrupt |

## Verification
Each result has a fixed due cycle:
- A request is due one cycle after the edge that accepts a start or ends a gap.
- The end flag is due one cycle after the edge that samples a matching `seq_done_i`.
- Chip select is due to stay low for exactly `CS_GAP` cycles after a mismatch.
- The interrupt follows the flag and its enable in the same cycle.

The bench drives inputs at the falling edge and steps a behavioural model at every rising edge. It compares every output with that model three nanoseconds after the falling edge, so each value is checked in the exact cycle it is due. A responder returns status words from a queue after a programmable latency, which lets the checks move the gap, stop and clear corners relative to the returning data.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int OPC_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_GAP,
    ST_DONE
  } poll_st_e;
endpackage

// File: rtl/fsp_lane_cmp.sv
module fsp_lane_cmp #(
  parameter int STAT_W = 16,
  parameter int SEL_W  = 1
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] exp_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              hit_o
);
  localparam int NB = STAT_W / 8;

  logic [NB-1:0] lane_ok;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic use_lane;
    logic [7:0] diff;
    assign use_lane    = (SEL_W'(b) <= sel_i);
    assign diff        = (stat_i[8*b +: 8] ^ exp_i[8*b +: 8]) & mask_i[8*b +: 8];
    assign lane_ok[b]  = !use_lane || (diff == 8'h00);
  end

  assign hit_o = &lane_ok;
endmodule

// File: rtl/fsp_gap_timer.sv
module fsp_gap_timer #(
  parameter int CS_GAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = $clog2(CS_GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(CS_GAP - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fsp_end_flag.sv
module fsp_end_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic end_o,
  output logic irq_o
);
  logic end_q;

  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     end_q <= 1'b0;
    else if (set_i)  end_q <= 1'b1;
    else if (clr_i)  end_q <= 1'b0;
  end

  assign end_o = end_q;
  assign irq_o = end_q & irq_en_i;
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int SEL_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              poll_en_i,
  input  logic              cmd_en_i,
  input  logic              cmd_16b_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [SEL_W-1:0]  stat_sel_i,
  input  logic [STAT_W-1:0] expect_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              seq_done_i,
  input  logic              hit_i,
  input  logic              gap_expired_i,
  output logic              gap_load_o,
  output logic              end_set_o,
  output poll_st_e          state_o,
  output logic [OPC_W-1:0]  opc_q_o,
  output logic              cmd16_q_o,
  output logic [SEL_W-1:0]  sel_q_o,
  output logic [STAT_W-1:0] exp_q_o,
  output logic [STAT_W-1:0] mask_q_o
);
  poll_st_e st_q, st_d;
  logic     abort_q, abort_d;
  logic     cap;

  always_comb begin
    st_d       = st_q;
    abort_d    = abort_q;
    gap_load_o = 1'b0;
    end_set_o  = 1'b0;
    cap        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i && !stop_i && poll_en_i && cmd_en_i) begin
          st_d    = ST_REQ;
          cap     = 1'b1;
          abort_d = 1'b0;
        end
      end
      ST_REQ: begin
        st_d = ST_WAIT;
        if (stop_i) abort_d = 1'b1;
      end
      ST_WAIT: begin
        if (stop_i) abort_d = 1'b1;
        if (seq_done_i) begin
          abort_d = 1'b0;
          if (abort_q || stop_i) begin
            st_d = ST_IDLE;
          end else if (hit_i) begin
            st_d      = ST_DONE;
            end_set_o = 1'b1;
          end else begin
            st_d       = ST_GAP;
            gap_load_o = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (stop_i)             st_d = ST_IDLE;
        else if (gap_expired_i) st_d = ST_REQ;
      end
      ST_DONE: begin
        if (stop_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_d;
    end
  end

  // snapshot of the poll setup, taken when a start is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q_o   <= '0;
      cmd16_q_o <= 1'b0;
      sel_q_o   <= '0;
      exp_q_o   <= '0;
      mask_q_o  <= '0;
    end else if (cap) begin
      opc_q_o   <= opcode_i;
      cmd16_q_o <= cmd_16b_i;
      sel_q_o   <= stat_sel_i;
      exp_q_o   <= expect_i;
      mask_q_o  <= mask_i;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/flash_stat_poller.sv
module flash_stat_poller
  import fsp_pkg::*;
#(
  parameter int  STAT_W = 16,
  parameter int  CS_GAP = 2,
  localparam int NB     = STAT_W / 8,
  localparam int SEL_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              poll_en_i,
  input  logic              cmd_en_i,
  input  logic              cmd_16b_i,
  input  logic [15:0]       opcode_i,
  input  logic [SEL_W-1:0]  stat_sel_i,
  input  logic [STAT_W-1:0] expect_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              end_clr_i,
  input  logic              irq_en_i,
  output logic              seq_req_o,
  output logic              seq_cs_o,
  output logic [15:0]       seq_opcode_o,
  output logic              seq_cmd_16b_o,
  output logic [SEL_W-1:0]  seq_stat_sel_o,
  input  logic              seq_done_i,
  input  logic [STAT_W-1:0] seq_stat_i,
  output logic              busy_o,
  output logic              end_o,
  output logic              irq_o
);
  poll_st_e          st;
  logic              hit, gap_load, gap_expired, end_set, cmd16_q;
  logic [OPC_W-1:0]  opc_q;
  logic [SEL_W-1:0]  sel_q;
  logic [STAT_W-1:0] exp_q, mask_q;

  fsp_ctrl #(.STAT_W(STAT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .poll_en_i     (poll_en_i),
    .cmd_en_i      (cmd_en_i),
    .cmd_16b_i     (cmd_16b_i),
    .opcode_i      (opcode_i),
    .stat_sel_i    (stat_sel_i),
    .expect_i      (expect_i),
    .mask_i        (mask_i),
    .seq_done_i    (seq_done_i),
    .hit_i         (hit),
    .gap_expired_i (gap_expired),
    .gap_load_o    (gap_load),
    .end_set_o     (end_set),
    .state_o       (st),
    .opc_q_o       (opc_q),
    .cmd16_q_o     (cmd16_q),
    .sel_q_o       (sel_q),
    .exp_q_o       (exp_q),
    .mask_q_o      (mask_q)
  );

  fsp_lane_cmp #(.STAT_W(STAT_W), .SEL_W(SEL_W)) u_cmp (
    .stat_i (seq_stat_i),
    .exp_i  (exp_q),
    .mask_i (mask_q),
    .sel_i  (sel_q),
    .hit_o  (hit)
  );

  fsp_gap_timer #(.CS_GAP(CS_GAP)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .expired_o (gap_expired)
  );

  fsp_end_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (end_set),
    .clr_i    (end_clr_i),
    .irq_en_i (irq_en_i),
    .end_o    (end_o),
    .irq_o    (irq_o)
  );

  assign seq_req_o      = (st == ST_REQ);
  assign seq_cs_o       = (st == ST_REQ) || (st == ST_WAIT);
  assign busy_o         = (st == ST_REQ) || (st == ST_WAIT) || (st == ST_GAP);
  assign seq_opcode_o   = cmd16_q ? opc_q : {8'h00, opc_q[7:0]};
  assign seq_cmd_16b_o  = cmd16_q;
  assign seq_stat_sel_o = sel_q;
endmodule

// File: rtl/flash_stat_poller_chk.sv
module flash_stat_poller_chk #(
  parameter int CS_GAP = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic poll_en_i,
  input logic cmd_en_i,
  input logic end_clr_i,
  input logic seq_req_o,
  input logic seq_cs_o,
  input logic busy_o,
  input logic end_o,
  input logic irq_o
);
  assert_req_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_req_o |=> !seq_req_o);

  assert_req_then_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_req_o |=> seq_cs_o);

  assert_start_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i && poll_en_i && cmd_en_i));

  assert_end_halts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_o) |-> !busy_o);

  assert_irq_needs_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> end_o);

  assert_end_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !end_clr_i) |=> end_o);

  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !seq_cs_o) |=> !busy_o);

  if (CS_GAP >= 2) begin : g_gap
    assert_cs_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(seq_cs_o) |=> !seq_cs_o);
  end
endmodule

bind flash_stat_poller flash_stat_poller_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .poll_en_i (poll_en_i),
  .cmd_en_i  (cmd_en_i),
  .end_clr_i (end_clr_i),
  .seq_req_o (seq_req_o),
  .seq_cs_o  (seq_cs_o),
  .busy_o    (busy_o),
  .end_o     (end_o),
  .irq_o     (irq_o)
);

// File: tb/flash_stat_poller_test.sv
`timescale 1ns/1ps
module flash_stat_poller_test;
  localparam int CS_GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, poll_en = 0, cmd_en = 0, c16 = 0, clr = 0, irq_en = 0;
  logic [15:0] opc = 0, expv = 0, msk = 0, stat = 0;
  logic [0:0] sel = 0;
  logic done = 0;

  logic seq_req, seq_cs, seq_c16, busy, end_f, irq;
  logic [15:0] seq_opc;
  logic [0:0] seq_sel;

  int nchk = 0, nfail = 0, lat = 1, rsp_cnt = 0;
  bit finished = 0;
  logic [15:0] stat_q[$];

  always #5 clk = ~clk;

  flash_stat_poller #(.STAT_W(16), .CS_GAP(CS_GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .poll_en_i(poll_en), .cmd_en_i(cmd_en), .cmd_16b_i(c16), .opcode_i(opc),
    .stat_sel_i(sel), .expect_i(expv), .mask_i(msk), .end_clr_i(clr),
    .irq_en_i(irq_en), .seq_req_o(seq_req), .seq_cs_o(seq_cs),
    .seq_opcode_o(seq_opc), .seq_cmd_16b_o(seq_c16), .seq_stat_sel_o(seq_sel),
    .seq_done_i(done), .seq_stat_i(stat), .busy_o(busy), .end_o(end_f), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 request, 2 waiting, 3 gap, 4 finished
  int m_st = 0, m_gap = 0;
  bit m_abort = 0, m_end = 0, m_c16 = 0, m_sel = 0;
  logic [15:0] m_opc = 0, m_exp = 0, m_msk = 0;

  function automatic bit mdl_hit(logic [15:0] s, logic [15:0] e, logic [15:0] m, bit wide);
    for (int i = 0; i < 16; i++)
      if ((i < 8 || wide) && m[i] && (s[i] !== e[i])) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit set_e;
    set_e = 0;
    if (!rst_n) begin
      m_st = 0; m_gap = 0; m_abort = 0; m_end = 0;
      m_opc = 0; m_exp = 0; m_msk = 0; m_c16 = 0; m_sel = 0;
    end else begin
      case (m_st)
        0: if (start && !stop && poll_en && cmd_en) begin
             m_st = 1; m_abort = 0;
             m_opc = opc; m_c16 = c16; m_sel = sel[0]; m_exp = expv; m_msk = msk;
           end
        1: begin m_st = 2; if (stop) m_abort = 1; end
        2: begin
             if (done) begin
               if (m_abort || stop) m_st = 0;
               else if (mdl_hit(stat, m_exp, m_msk, m_sel)) begin m_st = 4; set_e = 1; end
               else begin m_st = 3; m_gap = CS_GAP; end
               m_abort = 0;
             end else if (stop) m_abort = 1;
           end
        3: if (stop) m_st = 0;
           else begin m_gap--; if (m_gap == 0) m_st = 1; end
        4: if (stop) m_st = 0;
        default: m_st = 0;
      endcase
      if (set_e) m_end = 1;
      else if (clr) m_end = 0;
    end
  end

  // per-cycle comparison, mid low phase
  always @(negedge clk) begin
    #3;
    if (rst_n && !finished) begin
      chk("R3 seq_req", seq_req, m_st == 1);
      chk("R5 seq_cs", seq_cs, (m_st == 1) || (m_st == 2));
      chk("R9 busy", busy, (m_st >= 1) && (m_st <= 3));
      chk("R6 end", end_f, m_end);
      chk("R7 irq", irq, m_end && irq_en);
      chk("R11 opcode", seq_opc, m_c16 ? m_opc : {8'h00, m_opc[7:0]});
      chk("R11 cmd16", seq_c16, m_c16);
      chk("R4 sel", seq_sel, m_sel);
    end
  end

  // sequencer responder
  always @(negedge clk) begin
    if (done) done = 0;
    if (seq_req) rsp_cnt = lat;
    else if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        done = 1;
        stat = (stat_q.size() > 0) ? stat_q.pop_front() : 16'hFFFF;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic wait_end(int maxc);
    for (int k = 0; k < maxc && !end_f; k++) @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", seq_req, 0);
    chk("R1 cs", seq_cs, 0);
    chk("R1 busy", busy, 0);
    chk("R1 end", end_f, 0);
    chk("R1 irq", irq, 0);

    // R2 gating
    poll_en = 0; cmd_en = 1;
    pulse_start(); cyc(2);
    chk("R2 no poll_en", busy, 0);
    poll_en = 1; cmd_en = 0;
    pulse_start(); cyc(2);
    chk("R2 no cmd_en", busy, 0);
    cmd_en = 1;

    // R4 byte compare, R5 gap, R6 end, R7 irq, R9 stop in finished state, R8 clear
    lat = 2; opc = 16'h1205; c16 = 0; sel = 0; expv = 16'h0000; msk = 16'h0001; irq_en = 1;
    stat_q = '{16'h0003, 16'h0001, 16'hAB00};
    pulse_start();
    wait_end(100);
    chk("R6 end after match", end_f, 1);
    chk("R7 irq enabled", irq, 1);
    @(negedge clk) irq_en = 0;
    @(negedge clk);
    chk("R7 irq masked", irq, 0);
    pulse_stop(); @(negedge clk);
    chk("R9 end kept after stop", end_f, 1);
    chk("R9 idle after stop", busy, 0);
    pulse_clr(); @(negedge clk);
    chk("R8 end cleared", end_f, 0);

    // R4 two-byte compare, R10 restart ignored, R11 setup captured
    lat = 3; opc = 16'h7170; c16 = 1; sel = 1; expv = 16'h8001; msk = 16'h8001; irq_en = 1;
    stat_q = '{16'h0001, 16'h7F01, 16'h8001};
    pulse_start();
    cyc(2);
    expv = 16'h0000; msk = 16'hFFFF; opc = 16'h0000;
    cyc(3);
    pulse_start();
    wait_end(200);
    chk("R4 wide match", end_f, 1);
    chk("R11 opcode held", seq_opc, 16'h7170);
    pulse_stop(); pulse_clr(); cyc(2);

    // R8 set wins over simultaneous clear
    lat = 1; c16 = 0; sel = 0; expv = 16'h0000; msk = 16'h0001;
    stat_q = '{16'h0000};
    clr = 1;
    pulse_start();
    wait_end(50);
    chk("R8 set beats clear", end_f, 1);
    @(negedge clk);
    chk("R8 cleared next cycle", end_f, 0);
    clr = 0;
    pulse_stop(); cyc(2);

    // R9 stop while a read is outstanding
    lat = 4; stat_q = '{16'h0000};
    pulse_start();
    pulse_stop();
    cyc(10);
    chk("R9 no end after abort", end_f, 0);
    chk("R9 idle after abort", busy, 0);

    // R9 stop during gap, R5
    lat = 1; stat_q = '{16'h0001, 16'h0001, 16'h0001};
    pulse_start();
    for (int k = 0; k < 50 && !(busy && !seq_cs); k++) @(negedge clk);
    chk("R5 gap reached", seq_cs, 0);
    pulse_stop(); cyc(2);
    chk("R9 idle from gap", busy, 0);
    chk("R9 no end from gap", end_f, 0);
    cyc(6);
    chk("R9 no later request", seq_req, 0);

    cyc(2);
    report();
  end
endmodule